// File: doc/BRIEF.md
# Three-Channel Analog Front End Frame Master

This block drives the digital end of a synchronous serial link to an analog front end. It divides the system clock into a serial bit clock, counts a fixed frame of bit periods, and raises a frame-start strobe at the beginning of each frame. The downlink line carries three channel words in fixed slots at the start of the frame. The uplink line is sampled in the same slots, so that three words arrive from the front end. The rest of the frame carries no data.

The words for the downlink are taken from parallel inputs once per frame, at the start of the first bit period. The captured uplink words appear on parallel outputs with a one-clock valid pulse once the last slot bit has been sampled. A frame-done pulse marks each frame boundary. A per-frame enable decides whether the third channel carries data in both directions.

Top module: `afe_frame_if`

## Requirements
- R1: A frame lasts exactly FRAME_LEN bit periods (default 864), numbered T1 to T864. Rising edges of `frameSync` are exactly FRAME_LEN rising edges of `serClk` apart.
- R2: `frameSync` changes together with a rising edge of `serClk`. It is high during T1 and the SYNC_HOLD-1 bit periods after it (SYNC_HOLD is clamped to 1..8), and low for the rest of the frame.
- R3: `dataDown` changes on rising edges of `serClk`, most significant bit first. Word 1 (16 bits) is sent in T1..T16, word 2 (16 bits) in T17..T32, and word 3 (8 bits) in T33..T40.
- R4: `dataDown` is low from T41 to the end of the frame.
- R5: `dataUp` is sampled on the falling edge of `serClk` in T1..T40, most significant bit first, with the same slot layout as R3. The captured bits appear on `rxWord1`, `rxWord2` and `rxWord3`.
- R6: `rxValid` is high for exactly one system clock per frame, right after the falling edge of T40, and the word outputs are updated at that moment.
- R7: `ch3Enable` is sampled at the start of T1. When it is 0, `dataDown` stays low in T33..T40 and `rxWord3` is presented as zero for that frame.
- R8: `txWord1`..`txWord3` are sampled at the rising edge that starts T1. Changes during the frame have no effect on the bits sent in that frame.
- R9: `frameDone` is high for one system clock, at the rising edge of `serClk` that ends T864 and starts the next T1.
- R10: `rst` is synchronous and active high. While it is asserted, `serClk`, `frameSync`, `dataDown`, `rxValid` and `frameDone` are low. The first `serClk` rising edge after release starts T1.
- R11: `serClk` is high for CLK_DIV/2 system clocks and low for CLK_DIV/2 system clocks (default CLK_DIV 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ch3Enable | input | 1 | Third channel in use, sampled at T1 |
| txWord1 | input | 16 | Downlink word for channel 1 |
| txWord2 | input | 16 | Downlink word for channel 2 |
| txWord3 | input | 8 | Downlink word for channel 3 |
| dataUp | input | 1 | Serial uplink data from the front end |
| serClk | output | 1 | Serial bit clock |
| frameSync | output | 1 | Frame start strobe |
| dataDown | output | 1 | Serial downlink data |
| rxWord1 | output | 16 | Captured uplink word, channel 1 |
| rxWord2 | output | 16 | Captured uplink word, channel 2 |
| rxWord3 | output | 8 | Captured uplink word, channel 3, zero when disabled |
| rxValid | output | 1 | One-clock pulse when the rx words are updated |
| frameDone | output | 1 | One-clock pulse at each frame boundary |

## Verification
The bench builds the block with SYNC_HOLD set to 3, CLK_DIV set to 4 and the full 864-period frame. A hold longer than one bit period shows that the strobe width follows the parameter and not a fixed single cycle. A four-clock bit period leaves room between each rising and falling edge, so a capture on the wrong edge or a downlink shift on the wrong edge gives wrong words. With the full frame length the idle tail, the frame boundary pulse and the frame spacing are checked at their real values.

// File: rtl/afe_frame_pkg.sv
package afe_frame_pkg;

  // Strobes and levels passed from the frame control to the datapath
  typedef struct packed {
    logic riseTick;    // this clock edge is a bit clock rising edge
    logic fallTick;    // this clock edge is a bit clock falling edge
    logic loadShadow;  // rising edge that starts T1
    logic shiftTx;     // rising edge that starts T2..last slot bit
    logic txActive;    // current bit period lies in a channel slot
    logic txCh3;       // current bit period lies in the third slot
    logic sampleRx;    // falling edge inside a channel slot
    logic lastRx;      // falling edge of the last slot bit
  } frameStrobes_t;

endpackage

// File: rtl/afe_frame_ctrl.sv
module afe_frame_ctrl
  import afe_frame_pkg::*;
#(
  parameter int FRAME_LEN = 864,
  parameter int CLK_DIV   = 4,
  parameter int SYNC_HOLD = 1,
  parameter int SLOT_BITS = 40,
  parameter int CH3_START = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic          serClk,
  output logic          frameSync,
  output logic          frameDone,
  output frameStrobes_t strobes
);

  localparam int CW   = $clog2(FRAME_LEN);
  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;
  localparam int HOLD = (SYNC_HOLD > 8) ? 8 : ((SYNC_HOLD < 1) ? 1 : SYNC_HOLD);
  localparam logic [CW-1:0] LAST_CYC = CW'(FRAME_LEN - 1);

  logic [PW-1:0] phase;
  logic [CW-1:0] cycCnt;
  logic [CW-1:0] nextCnt;
  logic          running;
  logic          serClkQ;
  logic          syncQ;
  logic          txActQ;
  logic          txCh3Q;
  logic          doneQ;
  logic          riseTick;
  logic          fallTick;

  assign riseTick = (phase == PW'(CLK_DIV - 1));
  assign fallTick = (phase == PW'(HALF - 1));
  assign nextCnt  = (cycCnt == LAST_CYC) ? '0 : cycCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      cycCnt  <= LAST_CYC;
      running <= 1'b0;
      serClkQ <= 1'b0;
      syncQ   <= 1'b0;
      txActQ  <= 1'b0;
      txCh3Q  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      phase <= riseTick ? '0 : phase + 1'b1;
      doneQ <= riseTick && running && (cycCnt == LAST_CYC);
      if (riseTick) begin
        running <= 1'b1;
        cycCnt  <= nextCnt;
        serClkQ <= 1'b1;
        syncQ   <= (nextCnt < CW'(HOLD));
        txActQ  <= (nextCnt < CW'(SLOT_BITS));
        txCh3Q  <= (nextCnt >= CW'(CH3_START)) && (nextCnt < CW'(SLOT_BITS));
      end else if (fallTick) begin
        serClkQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.riseTick   = riseTick;
    strobes.fallTick   = fallTick;
    strobes.loadShadow = riseTick && (nextCnt == '0);
    strobes.shiftTx    = riseTick && (nextCnt != '0) && (nextCnt < CW'(SLOT_BITS));
    strobes.txActive   = txActQ;
    strobes.txCh3      = txCh3Q;
    strobes.sampleRx   = fallTick && running && (cycCnt < CW'(SLOT_BITS));
    strobes.lastRx     = fallTick && running && (cycCnt == CW'(SLOT_BITS - 1));
  end

  assign serClk    = serClkQ;
  assign frameSync = syncQ;
  assign frameDone = doneQ;

  // R2: the frame strobe only rises together with the bit clock
  assert_sync_with_clk_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(syncQ) |-> $rose(serClkQ));

  // R9: the boundary pulse coincides with the strobe of the next frame
  assert_done_at_start_R9: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> (syncQ && serClkQ));

endmodule

// File: rtl/afe_frame_dp.sv
module afe_frame_dp
  import afe_frame_pkg::*;
#(
  parameter int CH1_W = 16,
  parameter int CH2_W = 16,
  parameter int CH3_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  frameStrobes_t     strobes,
  input  logic              ch3Enable,
  input  logic [CH1_W-1:0]  txWord1,
  input  logic [CH2_W-1:0]  txWord2,
  input  logic [CH3_W-1:0]  txWord3,
  input  logic              dataUp,
  output logic              dataDown,
  output logic [CH1_W-1:0]  rxWord1,
  output logic [CH2_W-1:0]  rxWord2,
  output logic [CH3_W-1:0]  rxWord3,
  output logic              rxValid
);

  localparam int SLOT_BITS = CH1_W + CH2_W + CH3_W;

  logic [SLOT_BITS-1:0] txReg;
  logic [SLOT_BITS-1:0] rxReg;
  logic [SLOT_BITS-1:0] rxFull;
  logic                 ch3EnFrame;
  logic                 rxValidQ;

  assign rxFull = {rxReg[SLOT_BITS-2:0], dataUp};

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg      <= '0;
      rxReg      <= '0;
      ch3EnFrame <= 1'b0;
      rxWord1    <= '0;
      rxWord2    <= '0;
      rxWord3    <= '0;
      rxValidQ   <= 1'b0;
    end else begin
      rxValidQ <= 1'b0;
      if (strobes.loadShadow) begin
        txReg      <= {txWord1, txWord2, (ch3Enable ? txWord3 : {CH3_W{1'b0}})};
        ch3EnFrame <= ch3Enable;
      end else if (strobes.shiftTx) begin
        txReg <= {txReg[SLOT_BITS-2:0], 1'b0};
      end
      if (strobes.sampleRx) begin
        rxReg <= rxFull;
      end
      if (strobes.lastRx) begin
        rxWord1  <= rxFull[SLOT_BITS-1 -: CH1_W];
        rxWord2  <= rxFull[CH2_W+CH3_W-1 -: CH2_W];
        rxWord3  <= ch3EnFrame ? rxFull[CH3_W-1:0] : {CH3_W{1'b0}};
        rxValidQ <= 1'b1;
      end
    end
  end

  assign dataDown = strobes.txActive & txReg[SLOT_BITS-1];
  assign rxValid  = rxValidQ;

  // R7: a disabled third channel never drives a one onto the line
  assert_ch3_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.txCh3 && !ch3EnFrame) |-> !dataDown);

  // R6: the capture strobe lasts a single clock
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rxValidQ |=> !rxValidQ);

endmodule

// File: rtl/afe_frame_if.sv
module afe_frame_if
  import afe_frame_pkg::*;
#(
  parameter int FRAME_LEN = 864,
  parameter int CLK_DIV   = 4,
  parameter int SYNC_HOLD = 1,
  parameter int CH1_W     = 16,
  parameter int CH2_W     = 16,
  parameter int CH3_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch3Enable,
  input  logic [CH1_W-1:0] txWord1,
  input  logic [CH2_W-1:0] txWord2,
  input  logic [CH3_W-1:0] txWord3,
  input  logic             dataUp,
  output logic             serClk,
  output logic             frameSync,
  output logic             dataDown,
  output logic [CH1_W-1:0] rxWord1,
  output logic [CH2_W-1:0] rxWord2,
  output logic [CH3_W-1:0] rxWord3,
  output logic             rxValid,
  output logic             frameDone
);

  localparam int SLOT_BITS = CH1_W + CH2_W + CH3_W;
  localparam int CH3_START = CH1_W + CH2_W;

  frameStrobes_t strobes;

  afe_frame_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .CLK_DIV   (CLK_DIV),
    .SYNC_HOLD (SYNC_HOLD),
    .SLOT_BITS (SLOT_BITS),
    .CH3_START (CH3_START)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .serClk    (serClk),
    .frameSync (frameSync),
    .frameDone (frameDone),
    .strobes   (strobes)
  );

  afe_frame_dp #(
    .CH1_W (CH1_W),
    .CH2_W (CH2_W),
    .CH3_W (CH3_W)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .ch3Enable (ch3Enable),
    .txWord1   (txWord1),
    .txWord2   (txWord2),
    .txWord3   (txWord3),
    .dataUp    (dataUp),
    .dataDown  (dataDown),
    .rxWord1   (rxWord1),
    .rxWord2   (rxWord2),
    .rxWord3   (rxWord3),
    .rxValid   (rxValid)
  );

  // R10: reset silences every output on the following edge
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!serClk && !frameSync && !dataDown && !rxValid && !frameDone));

endmodule

// File: tb/sim_afe_frame_if.sv
module sim_afe_frame_if;

  localparam int FL   = 864;
  localparam int DIV  = 4;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch3En = 1'b1;
  logic [15:0] tw1 = '0;
  logic [15:0] tw2 = '0;
  logic [7:0]  tw3 = '0;
  logic        dataUp = 1'b0;
  logic        serClk, frameSync, dataDown, rxValid, frameDone;
  logic [15:0] rw1, rw2;
  logic [7:0]  rw3;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  afe_frame_if #(
    .FRAME_LEN (FL),
    .CLK_DIV   (DIV),
    .SYNC_HOLD (HOLD)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .ch3Enable (ch3En),
    .txWord1   (tw1),
    .txWord2   (tw2),
    .txWord3   (tw3),
    .dataUp    (dataUp),
    .serClk    (serClk),
    .frameSync (frameSync),
    .dataDown  (dataDown),
    .rxWord1   (rw1),
    .rxWord2   (rw2),
    .rxWord3   (rw3),
    .rxValid   (rxValid),
    .frameDone (frameDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one system clock; reports bit clock and strobe rising edges
  task automatic stepClk(output bit clkRose, output bit syncRose);
    logic s0, f0;
    s0 = serClk;
    f0 = frameSync;
    @(negedge clk);
    clkRose  = serClk && !s0;
    syncRose = frameSync && !f0;
  endtask

  function automatic logic slotBit(input int t, input logic [15:0] a,
                                   input logic [15:0] b, input logic [7:0] c,
                                   input logic en);
    if (t >= 1 && t <= 16)       return a[16 - t];
    else if (t >= 17 && t <= 32) return b[32 - t];
    else if (t >= 33 && t <= 40) return en ? c[40 - t] : 1'b0;
    else                         return 1'b0;
  endfunction

  task automatic runFrame(input logic [15:0] w1, input logic [15:0] w2,
                          input logic [7:0] w3, input logic en,
                          input logic [15:0] u1, input logic [15:0] u2,
                          input logic [7:0] u3, input bit midChange,
                          input string name);
    bit r, fr;
    int t, syncErr, downErr, tailErr, validCnt, validT, doneEarly;
    logic [15:0] c1, c2;
    logic [7:0]  c3;
    tw1 = w1; tw2 = w2; tw3 = w3; ch3En = en;
    syncErr = 0; downErr = 0; tailErr = 0; validCnt = 0; validT = 0; doneEarly = 0;
    c1 = '0; c2 = '0; c3 = '0;
    dataUp = 1'b0;
    do stepClk(r, fr); while (!fr);
    t = 1;
    check(r, "R2", {name, " strobe rises with bit clock"}, 32'(r), 1);
    if (dataDown !== slotBit(1, w1, w2, w3, en)) downErr++;
    dataUp = slotBit(1, u1, u2, u3, 1'b1);
    forever begin
      stepClk(r, fr);
      if (rxValid) begin
        validCnt++; validT = t; c1 = rw1; c2 = rw2; c3 = rw3;
      end
      if (r) begin
        t++;
        if (t > FL) break;
        if (frameSync !== (t <= HOLD)) syncErr++;
        if (t <= 40) begin
          if (dataDown !== slotBit(t, w1, w2, w3, en)) downErr++;
        end else if (dataDown !== 1'b0) tailErr++;
        dataUp = (t <= 40) ? slotBit(t, u1, u2, u3, 1'b1) : 1'b0;
        if (midChange && t == 20) begin
          tw1 = ~w1; tw2 = ~w2; tw3 = ~w3; ch3En = ~en;
        end
      end
      if (frameDone && t <= FL) doneEarly++;
    end
    check(frameSync === 1'b1, "R1", {name, " next frame after FRAME_LEN bits"}, 32'(frameSync), 1);
    check(frameDone === 1'b1, "R9", {name, " frameDone at boundary"}, 32'(frameDone), 1);
    check(doneEarly == 0, "R9", {name, " no frameDone inside frame"}, doneEarly, 0);
    check(syncErr == 0, "R2", {name, " strobe width"}, syncErr, 0);
    check(downErr == 0, midChange ? "R8" : "R3", {name, " downlink slot bits"}, downErr, 0);
    check(tailErr == 0, "R4", {name, " idle tail low"}, tailErr, 0);
    check(validCnt == 1 && validT == 40, "R6", {name, " rxValid once in T40"},
          validCnt * 1000 + validT, 1040);
    check(c1 === u1, "R5", {name, " rxWord1"}, 32'(c1), 32'(u1));
    check(c2 === u2, "R5", {name, " rxWord2"}, 32'(c2), 32'(u2));
    check(c3 === (en ? u3 : 8'h00), en ? "R5" : "R7", {name, " rxWord3"},
          32'(c3), en ? 32'(u3) : 0);
    dataUp = 1'b0;
  endtask

  task automatic testClockShape();
    int hi, lo;
    bit r, fr;
    do stepClk(r, fr); while (!r);
    hi = 0; lo = 0;
    while (serClk) begin hi++; stepClk(r, fr); end
    while (!serClk) begin lo++; stepClk(r, fr); end
    check(hi == DIV / 2, "R11", "serClk high time", hi, DIV / 2);
    check(lo == DIV / 2, "R11", "serClk low time", lo, DIV / 2);
  endtask

  task automatic testMidReset();
    bit r, fr;
    int n;
    repeat (500) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!serClk && !frameSync && !dataDown && !rxValid && !frameDone, "R10",
          "outputs quiet in reset",
          {27'd0, serClk, frameSync, dataDown, rxValid, frameDone}, 0);
    rst = 1'b0;
    n = 0;
    do begin stepClk(r, fr); n++; end while (!r && n < 20);
    check(r && frameSync, "R10", "first rise after reset is T1", 32'(frameSync), 1);
    check(n <= DIV, "R10", "first rise within one bit period", n, DIV);
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!serClk && !frameSync && !dataDown && !rxValid && !frameDone, "R10",
          "reset state", {27'd0, serClk, frameSync, dataDown, rxValid, frameDone}, 0);
    @(negedge clk);
    rst = 1'b0;
    testClockShape();
    runFrame(16'hA5C3, 16'h1E96, 8'h5B, 1'b1, 16'h3C71, 16'hF00D, 8'hC4, 1'b0, "mixed");
    runFrame(16'hFFFF, 16'h0000, 8'hFF, 1'b0, 16'h8001, 16'h7FFE, 8'hFF, 1'b0, "ch3off");
    runFrame(16'h0F0F, 16'hC3A5, 8'h81, 1'b1, 16'h5555, 16'hAAAA, 8'h3C, 1'b1, "midupd");
    runFrame(16'h0000, 16'hFFFF, 8'h00, 1'b1, 16'hFFFF, 16'h0000, 8'h01, 1'b0, "edges");
    testMidReset();
    runFrame(16'h8421, 16'h1248, 8'h96, 1'b1, 16'h6A59, 16'h9D2E, 8'h7E, 1'b0, "postrst");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule